// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns a bank of protection-entry settings into explicit byte ranges. Each entry has a configuration byte and a word-granular address register. The configuration byte holds a two-bit match-mode field. The decoder gives every entry an inclusive start byte address, an inclusive end byte address and a flag that marks the range as usable. It handles disabled entries, top-of-range entries that take their lower bound from the entry below, fixed four-byte entries, and naturally aligned power-of-two entries whose size comes from the trailing ones of the address register.

Byte addresses are two bits wider than the address registers, so a 32-bit register bank describes a 34-bit byte space. With the `REGISTERED` parameter set, the decoded bounds are held in flops and follow their inputs one clock later. With it cleared, the bounds follow the inputs within the same cycle. The block only produces bounds. Comparing an access address against them is left to downstream logic.

Top module: `pmp_bounds_decoder`

## Requirements
- R1: The match mode of entry i is taken from bits [4:3] of its configuration byte, with 0 = disabled, 1 = top-of-range, 2 = four-byte, 3 = aligned power-of-two. All other configuration bits have no effect on any output.
- R2: A disabled entry reports valid = 0, start = 0 and end = 0.
- R3: A top-of-range entry i with address register A(i) greater than A(i-1) reports start = A(i-1)·4, end = A(i)·4 − 1 and valid = 1. Entry 0 uses 0 as A(i-1).
- R4: A top-of-range entry with A(i) ≤ A(i-1) is empty. It reports valid = 0, start = 0 and end = 0.
- R5: A four-byte entry reports start = A·4, end = A·4 + 3 and valid = 1.
- R6: An aligned power-of-two entry whose address register ends in k ones (and then a zero) covers 2^(k+3) bytes aligned to its own size. It reports start = x & (x+1) and end = x | (x+1), where x = A·4 + 3, with valid = 1.
- R7: An aligned power-of-two entry whose address register is all ones covers the whole byte space. It reports start = 0 and end = all ones across the full byte-address width.
- R8: A change to A(i) alone moves the start of entry i+1 with the same latency as its own outputs, whenever entry i+1 is in top-of-range mode.
- R9: With REGISTERED = 1, each output reflects the inputs present at the previous rising clock edge, and an active-low reset forces every valid flag, start and end to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | NUM_ENTRIES*8 | Configuration bytes, entry i at bits [8i+7:8i] |
| addr_i | input | NUM_ENTRIES*ADDR_W | Address registers, entry i at bits [ADDR_W*i +: ADDR_W] |
| start_o | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive start byte address per entry |
| end_o | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive end byte address per entry |
| valid_o | output | NUM_ENTRIES | Entry describes a non-empty enabled range |

## Verification
With the default registered build, every output is due exactly one rising edge after its inputs settle. This applies to the neighbour-driven start of a top-of-range entry as well. The bench changes inputs on the falling edge and samples one nanosecond after the next rising edge. To confirm the latency, it also samples once just before that edge, where the previous values must still be visible. Reset values are sampled while reset is held low, before any edge has loaded new data.

// File: rtl/pmp_bounds_pkg.sv
package pmp_bounds_pkg;

   typedef enum logic [1:0] {
      MATCH_OFF   = 2'd0,
      MATCH_TOR   = 2'd1,
      MATCH_NA4   = 2'd2,
      MATCH_NAPOT = 2'd3
   } match_mode_e;

   localparam int unsigned CFG_W        = 8;
   localparam int unsigned MODE_LSB     = 3;
   localparam int unsigned MODE_W       = 2;
   localparam int unsigned GRAIN_SHIFT  = 2;

endpackage

// File: rtl/pmp_napot_span.sv
module pmp_napot_span #(
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned BYTE_W = ADDR_W + 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] word_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic [BYTE_W-1:0] hi_o
);

   logic [BYTE_W-1:0] filled;
   logic [BYTE_W-1:0] bumped;

   // Appending two ones turns k trailing ones into k+2; the increment
   // clears them and sets the first zero, wrapping to 0 when all are set.
   assign filled = {word_i, 2'b11};
   assign bumped = filled + BYTE_W'(1);
   assign lo_o   = filled & bumped;
   assign hi_o   = filled | bumped;

   assert_full_space_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&word_i) |-> (lo_o == '0 && hi_o == '1));

endmodule

// File: rtl/pmp_entry_bounds.sv
module pmp_entry_bounds
   import pmp_bounds_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned BYTE_W = ADDR_W + 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] prev_addr_i,
   output logic [BYTE_W-1:0] start_o,
   output logic [BYTE_W-1:0] end_o,
   output logic              valid_o
);

   match_mode_e       mode;
   logic              tor_empty;
   logic [BYTE_W-1:0] napot_lo;
   logic [BYTE_W-1:0] napot_hi;

   assign mode      = match_mode_e'(mode_i);
   assign tor_empty = (addr_i <= prev_addr_i);

   pmp_napot_span #(.ADDR_W(ADDR_W)) u_napot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .word_i (addr_i),
      .lo_o   (napot_lo),
      .hi_o   (napot_hi)
   );

   always_comb begin
      start_o = '0;
      end_o   = '0;
      valid_o = 1'b0;
      unique case (mode)
         MATCH_TOR: begin
            if (!tor_empty) begin
               start_o = {prev_addr_i, 2'b00};
               end_o   = {addr_i, 2'b00} - BYTE_W'(1);
               valid_o = 1'b1;
            end
         end
         MATCH_NA4: begin
            start_o = {addr_i, 2'b00};
            end_o   = {addr_i, 2'b11};
            valid_o = 1'b1;
         end
         MATCH_NAPOT: begin
            start_o = napot_lo;
            end_o   = napot_hi;
            valid_o = 1'b1;
         end
         default: begin
            start_o = '0;
            end_o   = '0;
            valid_o = 1'b0;
         end
      endcase
   end

   logic [BYTE_W:0] span_w;
   assign span_w = {1'b0, end_o} - {1'b0, start_o};

   assert_off_never_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == MATCH_OFF) |-> !valid_o);

   assert_empty_is_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> (start_o == '0 && end_o == '0));

   assert_ordered_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (start_o <= end_o));

   assert_na4_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && mode == MATCH_NA4) |-> (span_w == (BYTE_W+1)'(3)));

   assert_napot_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && mode == MATCH_NAPOT) |->
         (((span_w + 1'b1) & span_w) == '0 && span_w >= (BYTE_W+1)'(7) &&
          ({1'b0, start_o} & span_w) == '0));

endmodule

// File: rtl/pmp_bounds_decoder.sv
module pmp_bounds_decoder
   import pmp_bounds_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned ADDR_W      = 32,
   parameter bit          REGISTERED  = 1'b1,
   localparam int unsigned BYTE_W     = ADDR_W + GRAIN_SHIFT
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [NUM_ENTRIES*CFG_W-1:0]  cfg_i,
   input  logic [NUM_ENTRIES*ADDR_W-1:0] addr_i,
   output logic [NUM_ENTRIES*BYTE_W-1:0] start_o,
   output logic [NUM_ENTRIES*BYTE_W-1:0] end_o,
   output logic [NUM_ENTRIES-1:0]        valid_o
);

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_entries
      $error("NUM_ENTRIES must lie in 1..64");
   end
   if (ADDR_W < 4 || ADDR_W > 62) begin : g_bad_width
      $error("ADDR_W must lie in 4..62");
   end

   logic [NUM_ENTRIES*BYTE_W-1:0] start_d;
   logic [NUM_ENTRIES*BYTE_W-1:0] end_d;
   logic [NUM_ENTRIES-1:0]        valid_d;
   logic [NUM_ENTRIES*(CFG_W-MODE_W)-1:0] unused_cfg_bits;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
      logic [ADDR_W-1:0] prev_addr;
      logic [CFG_W-1:0]  cfg_byte;

      assign cfg_byte = cfg_i[i*CFG_W +: CFG_W];
      assign unused_cfg_bits[i*(CFG_W-MODE_W) +: (CFG_W-MODE_W)] =
         {cfg_byte[CFG_W-1:MODE_LSB+MODE_W], cfg_byte[MODE_LSB-1:0]};

      if (i == 0) begin : g_first
         assign prev_addr = '0;
      end else begin : g_chain
         assign prev_addr = addr_i[(i-1)*ADDR_W +: ADDR_W];
      end

      pmp_entry_bounds #(.ADDR_W(ADDR_W)) u_entry (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .mode_i      (cfg_byte[MODE_LSB +: MODE_W]),
         .addr_i      (addr_i[i*ADDR_W +: ADDR_W]),
         .prev_addr_i (prev_addr),
         .start_o     (start_d[i*BYTE_W +: BYTE_W]),
         .end_o       (end_d[i*BYTE_W +: BYTE_W]),
         .valid_o     (valid_d[i])
      );
   end

   if (REGISTERED) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            start_o <= '0;
            end_o   <= '0;
            valid_o <= '0;
         end else begin
            start_o <= start_d;
            end_o   <= end_d;
            valid_o <= valid_d;
         end
      end

      assert_reset_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !$past(rst_ni) |-> (valid_o == '0 && start_o == '0 && end_o == '0));

      assert_follows_inputs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $stable(cfg_i) && $stable(addr_i) && $stable(valid_d))
            |=> $stable(valid_o));
   end else begin : g_comb
      assign start_o = start_d;
      assign end_o   = end_d;
      assign valid_o = valid_d;
   end

endmodule

// File: tb/pmp_bounds_decoder_tb.sv
`timescale 1ns/1ps
module pmp_bounds_decoder_tb;

   localparam int N  = 8;
   localparam int AW = 32;
   localparam int BW = AW + 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N*8-1:0]  cfg = '0;
   logic [N*AW-1:0] addr = '0;
   logic [N*BW-1:0] start_w;
   logic [N*BW-1:0] end_w;
   logic [N-1:0]    valid_w;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pmp_bounds_decoder #(.NUM_ENTRIES(N), .ADDR_W(AW), .REGISTERED(1'b1)) u_dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .cfg_i   (cfg),
      .addr_i  (addr),
      .start_o (start_w),
      .end_o   (end_w),
      .valid_o (valid_w)
   );

   task automatic set_entry(input int e, input logic [7:0] c, input logic [AW-1:0] a);
      cfg[e*8 +: 8]    = c;
      addr[e*AW +: AW] = a;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input int e, input logic v, input logic [BW-1:0] s,
                        input logic [BW-1:0] en, input string req);
      checks++;
      if (valid_w[e] !== v || start_w[e*BW +: BW] !== s || end_w[e*BW +: BW] !== en) begin
         errors++;
         $display("FAIL %s entry %0d: got v=%0b s=%h e=%h, expected v=%0b s=%h e=%h",
                  req, e, valid_w[e], start_w[e*BW +: BW], end_w[e*BW +: BW], v, s, en);
      end
   endtask

   task automatic t_reset();
      #1;
      for (int e = 0; e < N; e++) check(e, 1'b0, '0, '0, "R9 reset");
   endtask

   task automatic t_off();
      @(negedge clk);
      set_entry(2, 8'h07, 32'h1234_5678);
      step();
      check(2, 1'b0, '0, '0, "R2 off entry");
   endtask

   task automatic t_na4();
      @(negedge clk);
      set_entry(1, 8'h10, 32'h0000_1000);
      step();
      check(1, 1'b1, 34'h0_0000_4000, 34'h0_0000_4003, "R5 four-byte");
      @(negedge clk);
      set_entry(1, 8'h97, 32'h0000_1000);
      step();
      check(1, 1'b1, 34'h0_0000_4000, 34'h0_0000_4003, "R1 extra cfg bits ignored");
   endtask

   task automatic t_tor();
      @(negedge clk);
      set_entry(0, 8'h08, 32'h0000_0100);
      set_entry(1, 8'h08, 32'h0000_0200);
      set_entry(2, 8'h08, 32'h0000_0200);
      set_entry(3, 8'h08, 32'h0000_0100);
      step();
      check(0, 1'b1, 34'h0, 34'h0_0000_03FF, "R3 tor entry 0");
      check(1, 1'b1, 34'h0_0000_0400, 34'h0_0000_07FF, "R3 tor chained");
      check(2, 1'b0, '0, '0, "R4 tor equal bounds empty");
      check(3, 1'b0, '0, '0, "R4 tor inverted empty");
   endtask

   task automatic t_napot();
      @(negedge clk);
      set_entry(5, 8'h18, 32'h0000_2000);
      set_entry(6, 8'h18, 32'h0000_2003);
      set_entry(7, 8'h18, 32'hFFFF_FFFF);
      step();
      check(5, 1'b1, 34'h0_0000_8000, 34'h0_0000_8007, "R6 napot 8 bytes");
      check(6, 1'b1, 34'h0_0000_8000, 34'h0_0000_801F, "R6 napot 32 bytes");
      check(7, 1'b1, 34'h0, 34'h3_FFFF_FFFF, "R7 napot full space");
   endtask

   task automatic t_neighbour();
      @(negedge clk);
      set_entry(3, 8'h10, 32'h0000_0300);
      set_entry(4, 8'h08, 32'h0000_0400);
      step();
      check(4, 1'b1, 34'h0_0000_0C00, 34'h0_0000_0FFF, "R8 tor before change");
      @(negedge clk);
      addr[3*AW +: AW] = 32'h0000_0380;
      #1;
      check(4, 1'b1, 34'h0_0000_0C00, 34'h0_0000_0FFF, "R9 old value held before edge");
      step();
      check(4, 1'b1, 34'h0_0000_0E00, 34'h0_0000_0FFF, "R8 neighbour refresh");
      check(3, 1'b1, 34'h0_0000_0E00, 34'h0_0000_0E03, "R5 moved four-byte");
   endtask

   initial begin
      t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_off();
      t_na4();
      t_tor();
      t_napot();
      t_neighbour();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule